// File: doc/BRIEF.md
# Lockable Four-Way LRU Victim Selector

This block picks the line to evict in a four-way set-associative cache that holds 16 KB in 32-byte lines, so 128 sets. For every set it stores a full recency order of the four ways as a rank per way. Rank 0 marks the least recently used way and the top rank marks the most recent. Every access hit or line fill names a set and a way. That way becomes the most recent, and the ways that were more recent than it each move down one rank.

When a miss needs space, the cache controller raises a victim request for a set. The block answers in the same cycle with the least recently used way among the ways that are not locked. Software can fence off the lowest-numbered ways with a lock count. It can also freeze the whole cache. In that case a request gets a no-allocate answer instead of a way. Locks only limit which way can be chosen as a victim: a hit on a locked way still refreshes its recency.

Top module: `lru_lock_repl`

## Requirements
- R1: After reset, every set orders its ways with way 0 least recent, then way 1, then way 2, and way 3 most recent. With no lock, a victim request on any set returns way 0.
- R2: An access (`acc_valid`=1) to a set and way makes that way the most recent in that set. The change is visible to a victim request from the next cycle on.
- R3: On an access, the ways that were more recent than the accessed way each drop one rank. The other ways keep their rank, so the relative order of the untouched ways is unchanged.
- R4: With `lock_ways`=0 and `lock_all`=0, a victim request returns the least recently used way of the indexed set.
- R5: `lock_ways` is an unsigned count from 0 to 3. A count of N keeps ways 0 to N-1 out of victim choice. The victim is then the least recently used of ways N to 3. A count of 3 always yields way 3.
- R6: While `lock_all`=1, a victim request drives `vict_none`=1 and `vict_way`=0, whatever the value of `lock_ways`.
- R7: Without a victim request, `vict_none`=0 and `vict_way`=0.
- R8: An access to a way that is covered by the lock count still makes that way the most recent. This shows in later victim choices once the lock is removed.
- R9: When an access and a victim request name the same set in one cycle, the victim is chosen from the order as it stood before that access.
- R10: An access changes only the order of its own set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Hit or fill on `acc_set`/`acc_way` this cycle |
| acc_set | input | 7 | Set index of the access |
| acc_way | input | 2 | Way that was hit or filled |
| vict_req | input | 1 | Victim wanted for `vict_set` |
| vict_set | input | 7 | Set index of the victim request |
| lock_ways | input | 2 | Number of low ways kept out of replacement (0 to 3) |
| lock_all | input | 1 | Whole cache locked, no allocation |
| vict_way | output | 2 | Way chosen for replacement |
| vict_none | output | 1 | Request refused because the cache is fully locked |

## Verification
An access and a victim request can land in the same cycle. If they name the same set, the victim must come from the old order while the new order is written at the clock edge. The random stimulus draws both set indices from a small pool, so the two collide often. A directed case also aims both at one fresh set. Both are judged by comparing the victim against a bench model that is updated only after the edge, and then checking that the next cycle's victim has moved on.

// File: rtl/lru_lock_pkg.sv
package lru_lock_pkg;
   localparam int unsigned DEFAULT_WAYS = 4;
   localparam int unsigned DEFAULT_SETS = 128;

   // what the victim port is answering in a given cycle
   typedef enum logic [1:0] {
      PICK_IDLE = 2'b00,
      PICK_WAY  = 2'b01,
      PICK_NONE = 2'b10
   } pick_kind_e;
endpackage

// File: rtl/lru_rank_store.sv
module lru_rank_store
   import lru_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = DEFAULT_WAYS,
   parameter int unsigned NUM_SETS = DEFAULT_SETS,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS),
   localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [SET_W-1:0]                  wr_set,
   input  logic [NUM_WAYS-1:0][WAY_W-1:0]    wr_ranks,
   input  logic [SET_W-1:0]                  rd_a_set,
   output logic [NUM_WAYS-1:0][WAY_W-1:0]    rd_a_ranks,
   input  logic [SET_W-1:0]                  rd_b_set,
   output logic [NUM_WAYS-1:0][WAY_W-1:0]    rd_b_ranks
);
   logic [NUM_WAYS-1:0][WAY_W-1:0] rank_mem [NUM_SETS];

   // reset order: way index equals its rank (way 0 oldest)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               rank_mem[s][w] <= WAY_W'(w);
            end
         end
      end else if (wr_en) begin
         rank_mem[wr_set] <= wr_ranks;
      end
   end

   assign rd_a_ranks = rank_mem[rd_a_set];
   assign rd_b_ranks = rank_mem[rd_b_set];

   // ---- checks kept beside the storage ----
   logic [NUM_WAYS-1:0]             seen_a;
   logic [NUM_WAYS-1:0]             seen_b;
   logic                            wr_en_q;
   logic [SET_W-1:0]                wr_set_q;
   logic [NUM_WAYS-1:0][WAY_W-1:0]  wr_ranks_q;

   always_comb begin
      seen_a = '0;
      seen_b = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         seen_a[rd_a_ranks[w]] = 1'b1;
         seen_b[rd_b_ranks[w]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q    <= 1'b0;
         wr_set_q   <= '0;
         wr_ranks_q <= '0;
      end else begin
         wr_en_q    <= wr_en;
         wr_set_q   <= wr_set;
         wr_ranks_q <= wr_ranks;
      end
   end

   // each set always holds a permutation of ranks (order never degenerates)
   assert_rank_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&seen_a) && (&seen_b))
      else $error("rank set is not a permutation");

   // the order written by an access is what the set holds one cycle later
   assert_update_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> (rank_mem[wr_set_q] == wr_ranks_q))
      else $error("access update not visible next cycle");
endmodule

// File: rtl/lru_rank_update.sv
module lru_rank_update
   import lru_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = DEFAULT_WAYS,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS),
   localparam logic [WAY_W-1:0] TOP_RANK = WAY_W'(NUM_WAYS - 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              upd_valid,
   input  logic [WAY_W-1:0]                  hit_way,
   input  logic [NUM_WAYS-1:0][WAY_W-1:0]    old_ranks,
   output logic [NUM_WAYS-1:0][WAY_W-1:0]    new_ranks
);
   logic [WAY_W-1:0] hit_rank;

   assign hit_rank = old_ranks[hit_way];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      always_comb begin
         if (hit_way == WAY_W'(w)) begin
            new_ranks[w] = TOP_RANK;
         end else if (old_ranks[w] > hit_rank) begin
            new_ranks[w] = old_ranks[w] - WAY_W'(1);
         end else begin
            new_ranks[w] = old_ranks[w];
         end
      end
   end

   // relative order of every untouched pair must survive the update
   logic [NUM_WAYS-1:0][NUM_WAYS-1:0] pair_ok;

   for (genvar i = 0; i < NUM_WAYS; i++) begin : g_pi
      for (genvar j = 0; j < NUM_WAYS; j++) begin : g_pj
         assign pair_ok[i][j] = (hit_way == WAY_W'(i)) || (hit_way == WAY_W'(j)) ||
                                ((old_ranks[i] < old_ranks[j]) == (new_ranks[i] < new_ranks[j]));
      end
   end

   assert_order_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (&pair_ok))
      else $error("untouched ways changed relative order");

   // the accessed way ends up strictly above every other way
   logic [NUM_WAYS-1:0] above_all;
   for (genvar k = 0; k < NUM_WAYS; k++) begin : g_above
      assign above_all[k] = (hit_way == WAY_W'(k)) || (new_ranks[k] < new_ranks[hit_way]);
   end

   assert_hit_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (&above_all))
      else $error("accessed way is not the most recent");
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
   import lru_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = DEFAULT_WAYS,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req,
   input  logic                              lock_all,
   input  logic [WAY_W-1:0]                  lock_cnt,
   input  logic [NUM_WAYS-1:0][WAY_W-1:0]    ranks,
   output logic [WAY_W-1:0]                  vict_way,
   output logic                              vict_none
);
   logic [NUM_WAYS-1:0] eligible;
   logic [WAY_W-1:0]    best_way;
   logic [WAY_W-1:0]    best_rank;
   logic                found;
   pick_kind_e          kind;

   // lock count fences off the lowest-numbered ways
   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_elig
      assign eligible[w] = (WAY_W'(w) >= lock_cnt);
   end

   // oldest eligible way; ranks are unique so ties cannot occur
   always_comb begin
      best_way  = '0;
      best_rank = '1;
      found     = 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (eligible[w] && (!found || ranks[w] < best_rank)) begin
            best_way  = WAY_W'(w);
            best_rank = ranks[w];
            found     = 1'b1;
         end
      end
   end

   always_comb begin
      if (!req)          kind = PICK_IDLE;
      else if (lock_all) kind = PICK_NONE;
      else               kind = PICK_WAY;
   end

   assign vict_way  = (kind == PICK_WAY) ? best_way : '0;
   assign vict_none = (kind == PICK_NONE);

   logic [NUM_WAYS-1:0] no_older;
   for (genvar k = 0; k < NUM_WAYS; k++) begin : g_cmp
      assign no_older[k] = !eligible[k] || (ranks[vict_way] <= ranks[k]);
   end

   assert_victim_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !lock_all) |-> (&no_older))
      else $error("victim is not the oldest unlocked way");

   assert_victim_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !lock_all) |-> (vict_way >= lock_cnt) && !vict_none)
      else $error("victim chosen from a locked way");

   assert_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lock_all) |-> (vict_none && (vict_way == '0)))
      else $error("full lock did not refuse allocation");

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!vict_none && (vict_way == '0)))
      else $error("victim outputs active without request");
endmodule

// File: rtl/lru_lock_repl.sv
module lru_lock_repl
   import lru_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = DEFAULT_WAYS,
   parameter int unsigned NUM_SETS = DEFAULT_SETS,
   localparam int unsigned WAY_W = $clog2(NUM_WAYS),
   localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             vict_req,
   input  logic [SET_W-1:0] vict_set,
   input  logic [WAY_W-1:0] lock_ways,
   input  logic             lock_all,
   output logic [WAY_W-1:0] vict_way,
   output logic             vict_none
);
   // elaboration-time parameter checks
   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two, at least 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end

   logic [NUM_WAYS-1:0][WAY_W-1:0] acc_old_ranks;
   logic [NUM_WAYS-1:0][WAY_W-1:0] acc_new_ranks;
   logic [NUM_WAYS-1:0][WAY_W-1:0] vict_ranks;

   lru_rank_store #(
      .NUM_WAYS (NUM_WAYS),
      .NUM_SETS (NUM_SETS)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (acc_valid),
      .wr_set     (acc_set),
      .wr_ranks   (acc_new_ranks),
      .rd_a_set   (acc_set),
      .rd_a_ranks (acc_old_ranks),
      .rd_b_set   (vict_set),
      .rd_b_ranks (vict_ranks)
   );

   lru_rank_update #(
      .NUM_WAYS (NUM_WAYS)
   ) update_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (acc_valid),
      .hit_way   (acc_way),
      .old_ranks (acc_old_ranks),
      .new_ranks (acc_new_ranks)
   );

   // victim reads the pre-edge order, so a same-cycle access is not seen
   lru_victim_pick #(
      .NUM_WAYS (NUM_WAYS)
   ) pick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (vict_req),
      .lock_all  (lock_all),
      .lock_cnt  (lock_ways),
      .ranks     (vict_ranks),
      .vict_way  (vict_way),
      .vict_none (vict_none)
   );
endmodule

// File: tb/lru_lock_repl_tb.sv
module lru_lock_repl_tb_top;
   localparam int NW = 4;
   localparam int NS = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [6:0] acc_set = '0;
   logic [1:0] acc_way = '0;
   logic       vict_req = 1'b0;
   logic [6:0] vict_set = '0;
   logic [1:0] lock_ways = '0;
   logic       lock_all = 1'b0;
   logic [1:0] vict_way;
   logic       vict_none;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int rk [NS][NW];

   always #10 clk = ~clk;

   lru_lock_repl dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_way(acc_way), .vict_req(vict_req), .vict_set(vict_set),
      .lock_ways(lock_ways), .lock_all(lock_all),
      .vict_way(vict_way), .vict_none(vict_none)
   );

   function automatic int exp_victim(int s, int lk);
      int best = -1;
      for (int w = lk; w < NW; w++) begin
         if (best < 0 || rk[s][w] < rk[s][best]) best = w;
      end
      return best;
   endfunction

   function automatic void model_access(int s, int h);
      int r = rk[s][h];
      for (int w = 0; w < NW; w++) begin
         if (rk[s][w] > r) rk[s][w] = rk[s][w] - 1;
      end
      rk[s][h] = NW - 1;
   endfunction

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare outputs, model updates after the edge
   task automatic step(bit av, int as, int aw, bit vr, int vs, int lk, bit la, string tag);
      int ew, en;
      @(negedge clk);
      acc_valid = av; acc_set = 7'(as); acc_way = 2'(aw);
      vict_req = vr;  vict_set = 7'(vs); lock_ways = 2'(lk); lock_all = la;
      #2;
      if (!vr) begin ew = 0; en = 0; end
      else if (la) begin ew = 0; en = 1; end
      else begin ew = exp_victim(vs, lk); en = 0; end
      check(tag, int'(vict_way), ew);
      check(tag, int'(vict_none), en);
      @(posedge clk);
      #1;
      if (av) model_access(as, aw);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) rk[s][w] = w;
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;

      // R1 reset order seen through victim choice
      step(0, 0, 0, 1, 0,   0, 0, "R1");
      step(0, 0, 0, 1, 127, 0, 0, "R1");
      step(0, 0, 0, 1, 64,  2, 0, "R1");
      // R2 / R3: set 3 accessed way 0 then way 1
      step(1, 3, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 3, 0, 0, "R2");
      step(1, 3, 1, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 3, 0, 0, "R3");
      step(0, 0, 0, 1, 3, 3, 0, "R5");
      // R8: access a way covered by the lock, then unlock
      step(1, 5, 0, 1, 5, 1, 0, "R8");
      step(0, 0, 0, 1, 5, 0, 0, "R8");
      // R9: same-set access and victim in one cycle
      step(1, 9, 0, 1, 9, 0, 0, "R9");
      step(0, 0, 0, 1, 9, 0, 0, "R9");
      // R10: neighbour set untouched
      step(1, 20, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 21, 0, 0, "R10");
      step(0, 0, 0, 1, 20, 0, 0, "R10");
      // R6: full lock refuses allocation for every count
      for (int lk = 0; lk < NW; lk++) step(0, 0, 0, 1, 3, lk, 1, "R6");

      // random mix with a small set pool so collisions are common
      for (int i = 0; i < 4000; i++) begin
         bit av = 1'($urandom_range(0, 1));
         bit vr = 1'($urandom_range(0, 3) != 0);
         bit la = 1'($urandom_range(0, 9) == 0);
         int as = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, NS-1)) : int'($urandom_range(0, 5));
         int vs = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, NS-1)) : int'($urandom_range(0, 5));
         int aw = int'($urandom_range(0, NW-1));
         int lk = int'($urandom_range(0, NW-1));
         string tag;
         if (!vr) tag = "R7";
         else if (la) tag = "R6";
         else if (av && as == vs) tag = "R9";
         else if (lk > 0) tag = "R5";
         else tag = "R4";
         step(av, as, aw, vr, vs, lk, la, tag);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule